// File: doc/BRIEF.md
# Fast GPIO Register Port

This block is a memory-mapped controller for general-purpose pins. It is organised as a number of ports, each one a bank of pins. It is reached through a local bus that finishes every access in one cycle. Each port offers six word-sized registers:
- an output value that can be read and written;
- three write-only strobes that set, clear or invert chosen output bits in a single access;
- a read-only view of the pins;
- a direction word that selects, bit by bit, which pins the block drives.

Ports sit at a fixed stride of 0x40 bytes inside the block's address window. Inside each port the registers are laid out as follows:

| Offset | Register |
|--------|----------|
| 0x00 | output value |
| 0x04 | set strobe |
| 0x08 | clear strobe |
| 0x0C | toggle strobe |
| 0x10 | pin view |
| 0x14 | direction |

A master raises a request together with an address, a write flag and write data. For a legal register access the block answers with ready in the same cycle, and a write takes effect at the next clock edge. Any other access gets an error response one cycle later. That covers an unused offset, a port slot beyond the configured count, a misaligned address, or a write to the pin view. The master keeps its request raised until ready arrives.

Pins enter through a two-flop synchronizer. The output value and the direction word drive the pad data and the pad output-enable directly.

Top module: `gpio_fast_regport`

## Requirements
- R1: After a synchronous reset, every output value, direction word and synchronizer stage is zero. `pin_out`, `pin_oe`, `bus_ready` and `bus_error` are all low.
- R2: Writing offset 0x00 (output value) or 0x14 (direction) of port slot p replaces that word. The port's address is p×0x40 plus the offset. A later read at the same address returns the written value.
- R3: A write to offset 0x04 sets every output bit whose write-data bit is 1. All other output bits keep their value.
- R4: A write to offset 0x08 clears every output bit whose write-data bit is 1. All other output bits keep their value.
- R5: A write to offset 0x0C inverts every output bit whose write-data bit is 1. A write of all zeros leaves the output unchanged.
- R6: A read of offset 0x04, 0x08 or 0x0C completes without error and returns zero.
- R7: A read of offset 0x10 returns the port's pins as sampled through two flops. A pin change made before clock edge k can be read after edge k+1 and not after edge k alone.
- R8: In every cycle, `pin_out` slice p equals port p's output value and `pin_oe` slice p equals port p's direction word. A direction bit of 1 means the pin is driven.
- R9: A legal access raises `bus_ready` in the cycle of the request, with `bus_error` low.
- R10: An illegal access is one of four kinds:
  - an offset outside the six listed;
  - a port slot at or above the port count;
  - an address with nonzero bits [1:0];
  - a write to offset 0x10.

  An illegal access gives no ready in its first cycle. In the next cycle it gives `bus_ready` and `bus_error` together, with read data zero. It changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block window |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Read data, valid while ready is high |
| bus_ready | output | 1 | Access completes this cycle |
| bus_error | output | 1 | Completing access is an error |
| pin_in | input | NUM_PORTS×PORT_W | Pad input levels, port p at slice p |
| pin_out | output | NUM_PORTS×PORT_W | Pad output data, port p at slice p |
| pin_oe | output | NUM_PORTS×PORT_W | Pad output enable, port p at slice p |

## Verification
The bench builds the block with two ports of 32 pins and an 8-bit address window. That window holds four port slots, so slots 0x80 and 0xC0 are decodable but unpopulated, and the out-of-range-port error path can be reached next to the unused-offset, misaligned and pin-view-write errors. A 32-bit port width lets all-ones toggle patterns and mixed set/clear masks exercise every bit of a word. A second port proves that strobes and writes stay inside the addressed port.

// File: rtl/gpio_fast_pkg.sv
package gpio_fast_pkg;

    // Byte distance between consecutive port banks, as a bit position.
    localparam int STRIDE_LSB = 6;

    typedef enum logic [2:0] {
        K_OUT  = 3'd0,
        K_SET  = 3'd1,
        K_CLR  = 3'd2,
        K_TOG  = 3'd3,
        K_IN   = 3'd4,
        K_DIR  = 3'd5,
        K_NONE = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic      hit;   // legal access for this direction
        reg_kind_e kind;  // register addressed inside the bank
    } dec_s;

    // Offset inside a bank -> register kind. Misaligned offsets miss.
    function automatic reg_kind_e kind_of(input logic [STRIDE_LSB-1:0] off);
        case (off)
            6'h00:   kind_of = K_OUT;
            6'h04:   kind_of = K_SET;
            6'h08:   kind_of = K_CLR;
            6'h0C:   kind_of = K_TOG;
            6'h10:   kind_of = K_IN;
            6'h14:   kind_of = K_DIR;
            default: kind_of = K_NONE;
        endcase
    endfunction

    function automatic logic is_strobe(input reg_kind_e k);
        is_strobe = (k == K_SET) || (k == K_CLR) || (k == K_TOG);
    endfunction

endpackage

// File: rtl/gpio_fast_decode.sv
module gpio_fast_decode
    import gpio_fast_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    output dec_s                         dec,
    output logic [ADDR_W-STRIDE_LSB-1:0] slot
);
    localparam int SLOT_W = ADDR_W - STRIDE_LSB;
    localparam logic [SLOT_W:0] PORTS_L = (SLOT_W+1)'(NUM_PORTS);

    reg_kind_e kind;
    logic      slot_ok;

    always_comb begin
        slot    = addr[ADDR_W-1:STRIDE_LSB];
        kind    = kind_of(addr[STRIDE_LSB-1:0]);
        slot_ok = ({1'b0, slot} < PORTS_L);
        dec.kind = kind;
        dec.hit  = slot_ok && (kind != K_NONE) && !(we && kind == K_IN);
    end

endmodule

// File: rtl/gpio_fast_bus.sv
module gpio_fast_bus (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic hit,
    output logic commit,
    output logic ready,
    output logic error
);
    logic err_pend_q;

    always_comb begin
        commit = req && hit && !err_pend_q;
        ready  = commit || err_pend_q;
        error  = err_pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) err_pend_q <= 1'b0;
        else     err_pend_q <= req && !hit && !err_pend_q;
    end

    // R9: a legal request completes in its own cycle without error
    p_zero_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (req && hit && !err_pend_q) |-> (ready && !error));

    // R10: a bad request waits one cycle, then finishes with error
    p_err_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (req && !hit && !err_pend_q) |-> !ready);
    p_err_done_r10: assert property (@(posedge clk) disable iff (rst)
        (req && !hit && !err_pend_q) |=> (ready && error));
    p_err_single_r10: assert property (@(posedge clk) disable iff (rst)
        error |=> !error);

endmodule

// File: rtl/gpio_fast_port.sv
module gpio_fast_port
    import gpio_fast_pkg::*;
#(
    parameter int PORT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] in_q
);
    logic [PORT_W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            case (kind)
                K_OUT:   out_q <= wdata;
                K_SET:   out_q <= out_q | wdata;
                K_CLR:   out_q <= out_q & ~wdata;
                K_TOG:   out_q <= out_q ^ wdata;
                K_DIR:   dir_q <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            in_q   <= '0;
        end else begin
            meta_q <= pin_in;
            in_q   <= meta_q;
        end
    end

    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == K_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == K_CLR) |=> ((out_q & $past(wdata)) == '0));
    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == K_TOG) |=> (out_q == ($past(out_q) ^ $past(wdata))));
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_fast_regport.sv
module gpio_fast_regport
    import gpio_fast_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    output logic                        bus_ready,
    output logic                        bus_error,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_out,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe
);
    localparam int SLOT_W = ADDR_W - STRIDE_LSB;

    dec_s              dec;
    logic [SLOT_W-1:0] slot;
    logic              commit;

    logic [PORT_W-1:0] out_a [NUM_PORTS];
    logic [PORT_W-1:0] dir_a [NUM_PORTS];
    logic [PORT_W-1:0] in_a  [NUM_PORTS];

    gpio_fast_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) i_dec (
        .we   (bus_we),
        .addr (bus_addr),
        .dec  (dec),
        .slot (slot)
    );

    gpio_fast_bus i_bus (
        .clk    (clk),
        .rst    (rst),
        .req    (bus_req),
        .hit    (dec.hit),
        .commit (commit),
        .ready  (bus_ready),
        .error  (bus_error)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_en;
        assign wr_en = commit && bus_we && (slot == SLOT_W'(p));

        gpio_fast_port #(.PORT_W(PORT_W)) i_port (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en),
            .kind   (dec.kind),
            .wdata  (bus_wdata),
            .pin_in (pin_in[p*PORT_W +: PORT_W]),
            .out_q  (out_a[p]),
            .dir_q  (dir_a[p]),
            .in_q   (in_a[p])
        );

        assign pin_out[p*PORT_W +: PORT_W] = out_a[p];
        assign pin_oe [p*PORT_W +: PORT_W] = dir_a[p];
    end

    always_comb begin
        bus_rdata = '0;
        if (commit && !bus_we) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (slot == SLOT_W'(p)) begin
                    case (dec.kind)
                        K_OUT:   bus_rdata = out_a[p];
                        K_IN:    bus_rdata = in_a[p];
                        K_DIR:   bus_rdata = dir_a[p];
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R6: strobe reads return zero
    p_strobe_rd_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_ready && !bus_we && !bus_error && is_strobe(dec.kind)) |-> (bus_rdata == '0));
    // R10: an error completion carries no data
    p_err_no_data_r10: assert property (@(posedge clk) disable iff (rst)
        bus_error |-> (bus_rdata == '0));
    // R2: reading port 0 output value shows the driven pad data
    p_rd_out_r2: assert property (@(posedge clk) disable iff (rst)
        (commit && !bus_we && dec.kind == K_OUT && slot == '0)
            |-> (bus_rdata == pin_out[PORT_W-1:0]));

endmodule

// File: tb/test_gpio_fast_regport.sv
`timescale 1ns/1ps
module test_gpio_fast_regport;
    localparam int NP = 2;
    localparam int PW = 32;
    localparam int AW = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_req = 1'b0;
    logic             bus_we = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [PW-1:0]    bus_wdata = '0;
    logic [PW-1:0]    bus_rdata;
    logic             bus_ready;
    logic             bus_error;
    logic [NP*PW-1:0] pin_in = '0;
    logic [NP*PW-1:0] pin_out;
    logic [NP*PW-1:0] pin_oe;

    gpio_fast_regport #(.NUM_PORTS(NP), .PORT_W(PW), .ADDR_W(AW)) i_gpio_fast_regport (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_error(bus_error),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #2 clk = ~clk;  // 250 MHz

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    // Behavioural reference model
    logic [PW-1:0]    out_m [NP];
    logic [PW-1:0]    dir_m [NP];
    logic [NP*PW-1:0] hist [$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) hist.delete();
        else begin
            hist.push_back(pin_in);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    function automatic logic [PW-1:0] exp_in(input int p);
        if (hist.size() < 2) return '0;
        return hist[hist.size()-2][p*PW +: PW];
    endfunction

    function automatic logic [PW-1:0] model_read(input logic [AW-1:0] a);
        int p = int'(a[7:6]);
        case (a[5:0])
            6'h00:   return out_m[p];
            6'h10:   return exp_in(p);
            6'h14:   return dir_m[p];
            default: return '0;
        endcase
    endfunction

    function automatic bit model_legal(input logic we, input logic [AW-1:0] a);
        if (a[7:6] >= NP) return 1'b0;
        case (a[5:0])
            6'h00, 6'h04, 6'h08, 6'h0C, 6'h14: return 1'b1;
            6'h10:   return !we;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [PW-1:0] d);
        int p = int'(a[7:6]);
        case (a[5:0])
            6'h00: out_m[p] = d;
            6'h04: out_m[p] = out_m[p] | d;
            6'h08: out_m[p] = out_m[p] & ~d;
            6'h0C: out_m[p] = out_m[p] ^ d;
            6'h14: dir_m[p] = d;
            default: ;
        endcase
    endtask

    // Pad outputs compared with the model on every clock (R8)
    always @(negedge clk) begin
        if (running) begin
            chk(pin_out == {out_m[1], out_m[0]}, "R8 pin_out", pin_out, {out_m[1], out_m[0]});
            chk(pin_oe  == {dir_m[1], dir_m[0]}, "R8 pin_oe",  pin_oe,  {dir_m[1], dir_m[0]});
        end
    end

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [PW-1:0] d, input string tag);
        logic [PW-1:0] er;
        bit legal = model_legal(we, a);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        if (legal) begin
            chk(bus_ready === 1'b1 && bus_error === 1'b0, "R9 ready/error", {bus_ready, bus_error}, 2'b10);
            if (!we) begin
                er = model_read(a);
                chk(bus_rdata == er, tag, bus_rdata, er);
            end
            @(posedge clk);
            if (we) model_write(a, d);
        end else begin
            chk(bus_ready === 1'b0 && bus_error === 1'b0, "R10 first cycle", {bus_ready, bus_error}, 2'b00);
            @(posedge clk);
            @(negedge clk);
            #1;
            chk(bus_ready === 1'b1 && bus_error === 1'b1, "R10 second cycle", {bus_ready, bus_error}, 2'b11);
            chk(bus_rdata == '0, "R10 rdata", bus_rdata, 0);
            @(posedge clk);
        end
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin out_m[p] = '0; dir_m[p] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state at the ports
        chk(pin_out == '0, "R1 pin_out", pin_out, 0);
        chk(pin_oe == '0, "R1 pin_oe", pin_oe, 0);
        chk(bus_ready == 1'b0 && bus_error == 1'b0, "R1 handshake", {bus_ready, bus_error}, 0);
        running = 1'b1;
        access(0, 8'h00, '0, "R1 read out A");
        access(0, 8'h14, '0, "R1 read dir A");
        access(0, 8'h10, '0, "R1 read in A");
        access(0, 8'h54, '0, "R1 read dir B");

        // R2: plain words on both ports
        access(1, 8'h00, 32'hA5A5_0F0F, "R2 wr out A");
        access(0, 8'h00, '0, "R2 read out A");
        access(1, 8'h14, 32'hFFFF_0000, "R2 wr dir A");
        access(0, 8'h14, '0, "R2 read dir A");
        access(1, 8'h40, 32'h1234_5678, "R2 wr out B");
        access(1, 8'h54, 32'h0000_FFFF, "R2 wr dir B");
        access(0, 8'h40, '0, "R2 read out B");
        chk(pin_out[63:32] == 32'h1234_5678, "R8 literal out B", pin_out[63:32], 32'h1234_5678);
        chk(pin_oe[31:0] == 32'hFFFF_0000, "R8 literal oe A", pin_oe[31:0], 32'hFFFF_0000);

        // R3, R4, R5 strobes
        access(1, 8'h04, 32'h0000_F0F0, "R3 set A");
        chk(pin_out[31:0] == 32'hA5A5_FFFF, "R3 set result", pin_out[31:0], 32'hA5A5_FFFF);
        access(1, 8'h08, 32'hA500_000F, "R4 clear A");
        chk(pin_out[31:0] == 32'h00A5_FFF0, "R4 clear result", pin_out[31:0], 32'h00A5_FFF0);
        access(1, 8'h0C, 32'hFFFF_FFFF, "R5 toggle A");
        chk(pin_out[31:0] == 32'hFF5A_000F, "R5 toggle result", pin_out[31:0], 32'hFF5A_000F);
        access(1, 8'h0C, 32'h0000_0000, "R5 toggle zero");
        chk(pin_out[31:0] == 32'hFF5A_000F, "R5 toggle zero result", pin_out[31:0], 32'hFF5A_000F);
        access(1, 8'h48, 32'hFFFF_0000, "R4 clear B");
        chk(pin_out[63:32] == 32'h0000_5678, "R4 clear B result", pin_out[63:32], 32'h0000_5678);
        access(1, 8'h44, 32'h8000_0001, "R3 set B");
        access(0, 8'h40, '0, "R3 read out B");

        // R6: strobe reads
        access(0, 8'h04, '0, "R6 read set A");
        access(0, 8'h08, '0, "R6 read clear A");
        access(0, 8'h4C, '0, "R6 read toggle B");

        // R7: synchronizer latency, literal values
        @(negedge clk); pin_in = {32'hCAFE_0001, 32'h1357_9BDF};
        @(negedge clk);  // one edge has sampled the new pins
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h10; #1;
        chk(bus_rdata == 32'h0000_0000, "R7 one edge", bus_rdata, 0);
        @(negedge clk); #1;  // second edge passed
        chk(bus_rdata == 32'h1357_9BDF, "R7 two edges", bus_rdata, 32'h1357_9BDF);
        bus_addr = 8'h50; #1;
        chk(bus_rdata == 32'hCAFE_0001, "R7 port B", bus_rdata, 32'hCAFE_0001);
        @(negedge clk); bus_req = 1'b0;
        pin_in = {32'h0F0F_0F0F, 32'hF0F0_F0F0};
        access(0, 8'h10, '0, "R7 model A");
        access(0, 8'h50, '0, "R7 model B");

        // R10: illegal accesses of every kind
        access(0, 8'h18, '0, "R10 unused offset read");
        access(1, 8'h3C, 32'hFFFF_FFFF, "R10 unused offset write");
        access(1, 8'h80, 32'hFFFF_FFFF, "R10 slot out of range");
        access(1, 8'hC4, 32'hFFFF_FFFF, "R10 slot out of range set");
        access(1, 8'h02, 32'h0000_0000, "R10 misaligned");
        access(1, 8'h10, 32'hFFFF_FFFF, "R10 write pin view");
        access(1, 8'h55, 32'h0, "R10 misaligned dir B");
        access(0, 8'h00, '0, "R10 out A unchanged");
        access(0, 8'h54, '0, "R10 dir B unchanged");

        repeat (3) @(negedge clk);
        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule